// File: doc/BRIEF.md
# Bus Slave Ready Return Handshake

This block closes slave accesses to the I/O register space of a 32-bit local-bus peripheral. It watches the address strobe, a chip-select address match and three cycle qualifiers. The qualifiers are write/read, data/control and memory/IO. It accepts only I/O data cycles. Once it accepts an access, it waits a fixed latency and then pulses its ready output for exactly one bus clock. It holds no ready for longer than that, whatever the length of the access.

Writes and reads end in different ways. A write ends in the clock in which ready is pulsed, and the ready-return input plays no part in it. A read keeps its data driven, with a separate data-output enable high, until the ready-return input is sampled low on a clock edge. That input carries the system's acknowledgement that the data was taken. The same block therefore works in two systems: one with separate ready and ready-return nets, and one where ready is tied straight back to ready-return.

The register contents live in a small internal array. The block has no streaming path, so all of its pins are plain strobes with no valid/ready back-pressure: ready is a single pulse, and ready-return is the only flow control. A new address strobe is looked at only while the block is idle.

Top module: `bus_slave_term`

## Requirements
- R1: After reset, `rdy_n` is high, `rd_oe` is low, `rd_data` is zero and every register reads back as zero.
- R2: An access starts on a clock edge where the block is idle, `ads_n` is low, `cs_hit` is high, `mio` is 0 (I/O) and `dc` is 1 (data). Any other combination starts nothing: `rdy_n` stays high and no register changes.
- R3: `rdy_n` is low for exactly one clock. It is low in the cycle that follows the RDY_LAT-th rising edge after the start edge (the third cycle after start, with RDY_LAT = 2).
- R4: On a read (`wr_rd` = 0), `rd_oe` is high and `rd_data` holds the addressed register from the ready cycle onward. Both stay that way until `rdy_rtn_n` is sampled low on a rising edge. `rd_oe` falls in the cycle after that edge.
- R5: While a read waits for ready-return, `rdy_n` stays high.
- R6: On a write (`wr_rd` = 1), `rdy_rtn_n` is ignored and `rd_oe` stays low. The write data and address latched at the start edge are stored at the end of the ready cycle, and the block is idle in the next cycle.
- R7: With `rdy_n` looped to `rdy_rtn_n`, a read ends at the edge that closes the ready cycle, and `rd_oe` is low in the cycle after it.
- R8: An address strobe seen while an access is in progress is ignored and writes nothing.
- R9: `rd_data` is zero whenever `rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low |
| cs_hit | input | 1 | Address matches this block's I/O window |
| wr_rd | input | 1 | 1 = write cycle, 0 = read cycle |
| dc | input | 1 | 1 = data cycle, 0 = control cycle |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| addr | input | AW | Register index |
| wr_data | input | DW | Write data, latched at the start edge |
| rdy_rtn_n | input | 1 | Ready-return acknowledgement, active low |
| rdy_n | output | 1 | Ready pulse, active low, one clock long |
| rd_data | output | DW | Read data, zero when not enabled |
| rd_oe | output | 1 | Read data-output enable |

## Verification
Reads are run with ready-return held off for zero to several cycles, and also with ready looped back. This shows apart a one-cycle pulse, a level held while waiting, and the early termination that loopback forces. Writes are run with ready-return driven low all through the access and with it left high, which shows whether the input really has no effect. Cycles with a wrong qualifier, a chip-select miss, or a strobe during a held read are followed by read-backs, which expose any stray register update. A seeded random mix of reads and writes is compared against a register model kept in the bench.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ISSUE,
    ST_HOLD
  } bst_state_e;

  // Only I/O data cycles belong to this block.
  function automatic logic is_io_data(input logic dc_v, input logic mio_v);
    return dc_v && !mio_v;
  endfunction
endpackage

// File: rtl/bst_decode.sv
module bst_decode
  import bst_pkg::*;
(
  input  logic ads_n,
  input  logic cs_hit,
  input  logic wr_rd,
  input  logic dc,
  input  logic mio,
  output logic req_rd,
  output logic req_wr
);
  logic claim;

  always_comb begin
    claim  = !ads_n && cs_hit && is_io_data(dc, mio);
    req_rd = claim && !wr_rd;
    req_wr = claim && wr_rd;
  end
endmodule

// File: rtl/bst_regfile.sv
module bst_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && (waddr == AW'(g)))    regs[g] <= wdata;
    end
  end

  always_comb rdata = regs[raddr];
endmodule

// File: rtl/bst_fsm.sv
module bst_fsm
  import bst_pkg::*;
#(
  parameter int NREGS   = 8,
  parameter int DW      = 32,
  parameter int RDY_LAT = 2,
  localparam int AW     = $clog2(NREGS),
  localparam int CW     = $clog2(RDY_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] reg_word,
  input  logic          rdy_rtn_n,
  output logic          rdy_n,
  output logic          rd_oe,
  output logic [DW-1:0] rd_word,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  bst_state_e    state;
  logic [CW-1:0] cnt;
  logic          is_wr_q;
  logic [DW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      is_wr_q <= 1'b0;
      word_q  <= '0;
      waddr   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_rd || req_wr) begin
          state   <= ST_WAIT;
          cnt     <= CW'(RDY_LAT);
          is_wr_q <= req_wr;
          waddr   <= addr;
          word_q  <= req_wr ? wr_data : reg_word;
        end
        ST_WAIT: begin
          if (cnt == CW'(1)) state <= ST_ISSUE;
          cnt <= cnt - CW'(1);
        end
        ST_ISSUE: begin
          if (is_wr_q || !rdy_rtn_n) state <= ST_IDLE;
          else                       state <= ST_HOLD;
        end
        ST_HOLD: if (!rdy_rtn_n) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rdy_n   = (state != ST_ISSUE);
    rd_oe   = ((state == ST_ISSUE) && !is_wr_q) || (state == ST_HOLD);
    rd_word = word_q;
    we      = (state == ST_ISSUE) && is_wr_q;
    wdata   = word_q;
  end

  AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |=> rdy_n); // R3
  AST_NO_RDY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> rdy_n); // R5
  AST_OE_DROP_ON_RTN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && !rdy_rtn_n) |=> !rd_oe); // R4
  AST_WR_ENDS_AT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && we) |=> (state == ST_IDLE)); // R6
  AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !rd_oe); // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && (state != ST_ISSUE) |=> $stable(waddr)); // R8
endmodule

// File: rtl/bus_slave_term.sv
module bus_slave_term
  import bst_pkg::*;
#(
  parameter int NREGS   = 8,
  parameter int DW      = 32,
  parameter int RDY_LAT = 2,
  localparam int AW     = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ads_n,
  input  logic          cs_hit,
  input  logic          wr_rd,
  input  logic          dc,
  input  logic          mio,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rdy_rtn_n,
  output logic          rdy_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe
);
  logic          req_rd, req_wr, we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata, reg_word, rd_word;

  bst_decode u_decode (
    .ads_n(ads_n), .cs_hit(cs_hit), .wr_rd(wr_rd), .dc(dc), .mio(mio),
    .req_rd(req_rd), .req_wr(req_wr)
  );

  bst_regfile #(.NREGS(NREGS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(addr), .rdata(reg_word)
  );

  bst_fsm #(.NREGS(NREGS), .DW(DW), .RDY_LAT(RDY_LAT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .addr(addr), .wr_data(wr_data), .reg_word(reg_word),
    .rdy_rtn_n(rdy_rtn_n), .rdy_n(rdy_n), .rd_oe(rd_oe),
    .rd_word(rd_word), .we(we), .waddr(waddr), .wdata(wdata)
  );

  always_comb rd_data = rd_oe ? rd_word : '0;

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && $past(rd_oe)) |-> $stable(rd_data)); // R4
  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_oe) |-> (rd_data == '0)); // R9
endmodule

// File: tb/test_bus_slave_term.sv
module test_bus_slave_term;
  localparam int NREGS = 8;
  localparam int DW    = 32;
  localparam int LAT   = 2;
  localparam int AW    = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ads_n = 1'b1, cs_hit = 1'b0, wr_rd = 1'b0, dc = 1'b1, mio = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic rtn_drv = 1'b1, loop_en = 1'b0;
  logic rdy_n, rd_oe;
  logic [DW-1:0] rd_data;
  wire  rdy_rtn_n = loop_en ? rdy_n : rtn_drv;

  int tests = 0, fails = 0;
  logic [DW-1:0] model [NREGS];

  always #2.5 clk = ~clk;

  bus_slave_term #(.NREGS(NREGS), .DW(DW), .RDY_LAT(LAT)) i_bus_slave_term (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cs_hit(cs_hit), .wr_rd(wr_rd),
    .dc(dc), .mio(mio), .addr(addr), .wr_data(wr_data), .rdy_rtn_n(rdy_rtn_n),
    .rdy_n(rdy_n), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  function automatic logic [DW-1:0] exp_read(input int a);
    return model[a];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One claimed access; k = hold cycles on a read, lp = ready looped back.
  task automatic access(input bit wr, input int a, input logic [DW-1:0] d,
                        input int k, input bit lp, input bit rtn_low, input bit poke);
    @(negedge clk);
    loop_en = lp; ads_n = 1'b0; cs_hit = 1'b1; mio = 1'b0; dc = 1'b1;
    wr_rd = wr; addr = AW'(a); wr_data = d;
    rtn_drv = (wr && rtn_low) ? 1'b0 : 1'b1;
    @(posedge clk);
    @(negedge clk);
    ads_n = 1'b1; addr = AW'($urandom); wr_data = $urandom;
    check("R3 no early ready", {31'd0, rdy_n}, 1);
    for (int i = 1; i < LAT; i++) begin
      @(negedge clk);
      check("R3 no early ready", {31'd0, rdy_n}, 1);
    end
    @(negedge clk);
    check("R3 ready cycle", {31'd0, rdy_n}, 0);
    if (wr) begin
      check("R6 no oe on write", {31'd0, rd_oe}, 0);
      model[a] = d;
      @(negedge clk);
      check("R6 write done", {30'd0, rdy_n, rd_oe}, 2'b10);
      rtn_drv = 1'b1;
      return;
    end
    check("R4 oe with ready", {31'd0, rd_oe}, 1);
    check("R4 read data", rd_data, exp_read(a));
    if (lp || k == 0) begin
      if (!lp) rtn_drv = 1'b0;
      @(negedge clk);
      check("R7 oe drops after loop", {31'd0, rd_oe}, 0);
      check("R9 data zero", rd_data, '0);
      check("R3 single pulse", {31'd0, rdy_n}, 1);
      rtn_drv = 1'b1;
    end else begin
      for (int i = 0; i < k; i++) begin
        @(negedge clk);
        check("R5 ready off in hold", {31'd0, rdy_n}, 1);
        check("R4 oe held", {31'd0, rd_oe}, 1);
        check("R4 data held", rd_data, exp_read(a));
        if (poke && i == 0) begin
          ads_n = 1'b0; wr_rd = 1'b1; addr = AW'((a + 1) % NREGS); wr_data = 32'hDEAD_BEEF;
        end else begin
          ads_n = 1'b1;
        end
      end
      ads_n = 1'b1;
      rtn_drv = 1'b0;
      @(negedge clk);
      check("R4 oe drops after rtn", {31'd0, rd_oe}, 0);
      check("R9 data zero", rd_data, '0);
      rtn_drv = 1'b1;
    end
  endtask

  task automatic stray(input bit cs, input bit m, input bit dcv, input int a);
    @(negedge clk);
    loop_en = 1'b0; ads_n = 1'b0; cs_hit = cs; mio = m; dc = dcv;
    wr_rd = 1'b1; addr = AW'(a); wr_data = 32'hBAD0_0000 | a;
    @(negedge clk);
    ads_n = 1'b1;
    for (int i = 0; i < LAT + 2; i++) begin
      check("R2 unclaimed no ready", {30'd0, rdy_n, rd_oe}, 2'b10);
      @(negedge clk);
    end
    mio = 1'b0; dc = 1'b1; cs_hit = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", {31'd0, rdy_n}, 1);
    check("R1 reset oe", {31'd0, rd_oe}, 0);
    check("R1 reset data", rd_data, '0);
    access(0, 3, '0, 1, 0, 0, 0);                 // R1 reads zero
    access(1, 2, 32'h1234_5678, 0, 0, 1, 0);      // R6 rtn low ignored
    access(0, 2, '0, 3, 0, 0, 0);                 // R4 hold three
    access(1, 5, 32'hA5A5_0F0F, 0, 1, 0, 0);      // R6 looped write
    access(0, 5, '0, 0, 1, 0, 0);                 // R7 looped read
    access(0, 2, '0, 0, 0, 0, 0);                 // R7 rtn in ready cycle
    access(0, 2, '0, 2, 0, 0, 1);                 // R8 strobe while busy
    access(0, 3, '0, 1, 0, 0, 0);                 // R8 reg 3 untouched
    stray(0, 0, 1, 4);                            // R2 cs miss
    stray(1, 1, 1, 4);                            // R2 memory cycle
    stray(1, 0, 0, 4);                            // R2 control cycle
    access(0, 4, '0, 1, 0, 0, 0);                 // R2 reg 4 still zero
    for (int n = 0; n < 40; n++) begin
      access($urandom % 2, $urandom % NREGS, $urandom, $urandom % 4,
             ($urandom % 4) == 0, $urandom % 2, 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule